// File: doc/BRIEF.md
# SMBus Target Register Device

This block is a bus target for a two-wire system management bus. A fast system clock samples the clock and data lines. The block pulls the data line low through an open-drain enable and never stretches the clock. Behind the bus logic sits a 256-byte register file. A host reaches it with the usual command transactions: plain byte, byte-data, word-data, block write, block read and process call. An incoming host-notify word needs no special handling. It is stored like any other word write.

In a write phase, the first byte after the address names a register. This is the command pointer, and it stays in place across transactions. Later write bytes go to consecutive locations starting at the pointer. A read phase, entered with a new START or a repeated START, streams bytes out starting from the last command written. Registers at or above a block base address act as block registers. On a write, the byte after the command is a count. The block stores that count, capped at 32, in the named register and places the data bytes behind it. A block read therefore returns the count first and the data after it.

Top module: `smbus_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `own_addr`. Bit 0 of that byte selects read (1) or write (0). On a mismatch the block does not drive SDA for the rest of the transaction and stores nothing.
- R2: In a write phase, the first data byte after the address is acknowledged and becomes the command pointer. It is not stored in the register file.
- R3: In a write phase to a non-block register, every later byte is acknowledged and stored at the current pointer, and the pointer then steps by one. A word arrives low byte first, so the low byte lands at the command address and the high byte at the command address plus one.
- R4: A read phase that follows a write phase through a repeated START returns bytes starting at the command just written. The pointer steps by one per byte, so a word is returned low byte first.
- R5: The command pointer persists across STOP. A read transaction with no command byte returns data starting at the most recent command, however many bytes were written after that command.
- R6: A command at or above the block base (default 0xC0) selects a block register. The next written byte is the count. It is acknowledged and stored at the command address, capped at 32. Up to that many data bytes follow at the command address plus one onward and are acknowledged. Any data byte beyond the stored count is not acknowledged and is not stored.
- R7: A block read from a block register returns the stored count byte first, then the data bytes that follow it.
- R8: When the host does not acknowledge a byte the block sent, the block leaves SDA released until the next START or STOP, so further clocks read as 0xFF.
- R9: The block begins pulling SDA low only while SCL is low. It releases SDA on any STOP or START. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high, each seen after a two-stage synchronizer.
- R10: After reset, SDA is released, every register reads 0 and the command pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Seven-bit bus address of this target |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A table of word write and readback pairs at scattered command addresses checks pointer loading, the low-then-high byte order, and the auto-increment inside one transaction. Directed sequences then cover cases the table cannot separate. A lone command byte followed by a plain read checks that the pointer persists and that the read starts from the command rather than the incremented write address. A foreign address checks that such a transaction leaves the register file untouched. Short and over-long block writes check the count cap and the refusal of excess bytes, and the block readback checks the count-first order. A read after a host refusal checks that the line stays released.

// File: rtl/smt_pkg.sv
package smt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_DEC,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_DEC,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NXT,
    ST_HOLD
  } link_state_e;
endpackage

// File: rtl/smt_line_sync.sv
module smt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic              scl_d_q, sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_d_q    <= scl_pipe_q[STAGES-1];
      sda_d_q    <= sda_pipe_q[STAGES-1];
    end
  end

  always_comb begin
    scl_s    = scl_pipe_q[STAGES-1];
    sda_s    = sda_pipe_q[STAGES-1];
    scl_rise = scl_s & ~scl_d_q;
    scl_fall = ~scl_s & scl_d_q;
    start_ev = scl_s & scl_d_q & sda_d_q & ~sda_s;
    stop_ev  = scl_s & scl_d_q & ~sda_d_q & sda_s;
  end
endmodule

// File: rtl/smt_regfile.sv
module smt_regfile #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/smt_engine.sv
module smt_engine
  import smt_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [AW-1:0] BLK_BASE = 8'hC0,
  parameter int          BLK_MAX  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    own_addr,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  localparam int CW = $clog2(BLK_MAX + 1);

  link_state_e   state_q, state_n;
  logic [2:0]    bit_q, bit_n;
  logic [7:0]    rx_q, rx_n, tx_q, tx_n;
  logic [AW-1:0] cmd_q, cmd_n, ptr_q, ptr_n;
  logic          first_q, first_n, blk_q, blk_n, cntp_q, cntp_n, drv_q, drv_n;
  logic [CW-1:0] left_q, left_n;
  logic [7:0]    cnt_clamp;
  logic          ack;

  assign cnt_clamp = (rx_q > 8'(BLK_MAX)) ? 8'(BLK_MAX) : rx_q;

  always_comb begin
    state_n = state_q;  bit_n  = bit_q;   rx_n   = rx_q;   tx_n  = tx_q;
    cmd_n   = cmd_q;    ptr_n  = ptr_q;   first_n = first_q;
    blk_n   = blk_q;    cntp_n = cntp_q;  left_n = left_q; drv_n = drv_q;
    wr_en   = 1'b0;     wr_data = rx_q;   ack    = 1'b1;
    case (state_q)
      ST_ADDR, ST_RX: if (scl_rise) begin
        rx_n  = {rx_q[6:0], sda_s};
        bit_n = bit_q + 3'd1;
        if (bit_q == 3'd7) state_n = (state_q == ST_ADDR) ? ST_ADDR_DEC : ST_RX_DEC;
      end
      ST_ADDR_DEC: if (scl_fall) begin
        if (rx_q[7:1] == own_addr) begin
          drv_n   = 1'b1;
          state_n = ST_ADDR_ACK;
          if (rx_q[0]) ptr_n = cmd_q;
          else         first_n = 1'b1;
        end else begin
          state_n = ST_HOLD;
        end
      end
      ST_ADDR_ACK: if (scl_fall) begin
        bit_n = '0;
        if (rx_q[0]) begin
          tx_n = rd_data; drv_n = ~rd_data[7]; state_n = ST_TX;
        end else begin
          drv_n = 1'b0; state_n = ST_RX;
        end
      end
      ST_RX_DEC: if (scl_fall) begin
        if (first_q) begin
          cmd_n   = AW'(rx_q);
          ptr_n   = AW'(rx_q);
          first_n = 1'b0;
          blk_n   = (AW'(rx_q) >= BLK_BASE);
          cntp_n  = (AW'(rx_q) >= BLK_BASE);
        end else if (cntp_q) begin
          wr_en   = 1'b1;
          wr_data = cnt_clamp;
          left_n  = CW'(cnt_clamp);
          ptr_n   = ptr_q + AW'(1);
          cntp_n  = 1'b0;
        end else if (blk_q && left_q == '0) begin
          ack = 1'b0;
        end else begin
          wr_en = 1'b1;
          ptr_n = ptr_q + AW'(1);
          if (blk_q) left_n = left_q - CW'(1);
        end
        if (ack) begin drv_n = 1'b1; state_n = ST_RX_ACK; end
        else     state_n = ST_HOLD;
      end
      ST_RX_ACK: if (scl_fall) begin
        drv_n = 1'b0; bit_n = '0; state_n = ST_RX;
      end
      ST_TX: if (scl_fall) begin
        if (bit_q == 3'd7) begin
          drv_n = 1'b0; bit_n = '0; state_n = ST_TX_ACK;
        end else begin
          tx_n  = {tx_q[6:0], 1'b0};
          drv_n = ~tx_q[6];
          bit_n = bit_q + 3'd1;
        end
      end
      ST_TX_ACK: if (scl_rise) begin
        ptr_n   = ptr_q + AW'(1);
        state_n = sda_s ? ST_HOLD : ST_TX_NXT;
      end
      ST_TX_NXT: if (scl_fall) begin
        tx_n = rd_data; drv_n = ~rd_data[7]; bit_n = '0; state_n = ST_TX;
      end
      default: ;
    endcase
    if (stop_ev) begin
      state_n = ST_IDLE; drv_n = 1'b0;
    end else if (start_ev) begin
      state_n = ST_ADDR; bit_n = '0; drv_n = 1'b0; first_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; bit_q <= '0; rx_q <= '0; tx_q <= '0;
      cmd_q <= '0; ptr_q <= '0; first_q <= 1'b0; blk_q <= 1'b0;
      cntp_q <= 1'b0; left_q <= '0; drv_q <= 1'b0;
    end else begin
      state_q <= state_n; bit_q <= bit_n; rx_q <= rx_n; tx_q <= tx_n;
      cmd_q <= cmd_n; ptr_q <= ptr_n; first_q <= first_n; blk_q <= blk_n;
      cntp_q <= cntp_n; left_q <= left_n; drv_q <= drv_n;
    end
  end

  assign rd_addr = ptr_q;
  assign wr_addr = ptr_q;
  assign sda_oe  = drv_q;
endmodule

// File: rtl/smbus_target.sv
module smbus_target #(
  parameter int AW       = 8,
  parameter int BLK_BASE = 8'hC0,
  parameter int BLK_MAX  = 32,
  parameter int STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] own_addr,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe
);
  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic          sda_s, scl_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  smt_line_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smt_engine #(.AW(AW), .BLK_BASE(AW'(BLK_BASE)), .BLK_MAX(BLK_MAX)) u_eng (
    .clk(clk), .rst_n(rst_int_n), .own_addr(own_addr), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  smt_regfile #(.AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/smt_checker.sv
module smt_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe,
  input logic wr_en
);
  // R9: pulling low begins only in the SCL low phase
  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R9: STOP releases the line
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
  // R9: START releases the line
  p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);
  // R6: every stored byte is acknowledged
  p_ack_on_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);
  // R3: storing happens at the end of a byte, in the SCL low phase
  p_store_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_s);
endmodule

bind smbus_target smt_checker u_chk (
  .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_oe(sda_oe), .wr_en(wr_en)
);

// File: tb/smbus_target_test.sv
module smbus_target_test;
  localparam logic [6:0] OWN = 7'h2A;
  localparam int Q  = 6;
  localparam int NV = 5;
  localparam logic [23:0] VEC [NV] = '{24'h00_12_34, 24'h10_A5_5A,
                                       24'h7E_00_FF, 24'hBE_01_80, 24'h40_FF_00};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic scl = 1'b1, hsda = 1'b1;
  logic sda_oe;
  wire  sda_line = hsda & ~sda_oe;

  smbus_target uut (.clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(scl),
                    .sda_i(sda_line), .sda_oe(sda_oe));

  int n_chk = 0, n_bad = 0, r9_bad = 0;
  logic oe_p = 1'b0;

  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_p && scl) r9_bad++;
    oe_p <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask
  task automatic go;   hsda = 1; qw; scl = 1; qw; hsda = 0; qw; scl = 0; qw; endtask
  task automatic halt; hsda = 0; qw; scl = 1; qw; hsda = 1; qw; endtask

  task automatic bit_io(input logic b, output logic r);
    hsda = b; qw; scl = 1; qw; r = sda_line; qw; scl = 0; qw;
  endtask

  task automatic send(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv(input logic host_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
    bit_io(~host_ack, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    rst_n = 0;
    repeat (5) @(negedge clk);
    chk("R10 released in reset", sda_oe, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R10: plain read after reset, pointer 0, register 0
    go; send({OWN, 1'b1}, a); chk("R1 read address ACK", a, 1);
    recv(0, d); chk("R10 reset register", d, 8'h00); halt;

    // Table: word write then word read through repeated START
    for (int v = 0; v < NV; v++) begin
      go; send({OWN, 1'b0}, a); chk("R1 write address ACK", a, 1);
      send(VEC[v][23:16], a); chk("R2 command ACK", a, 1);
      send(VEC[v][15:8], a);  chk("R3 low byte ACK", a, 1);
      send(VEC[v][7:0], a);   chk("R3 high byte ACK", a, 1);
      halt;
      go; send({OWN, 1'b0}, a); send(VEC[v][23:16], a);
      go; send({OWN, 1'b1}, a); chk("R4 read after repeated START ACK", a, 1);
      recv(1, d); chk("R4 low byte first", d, VEC[v][15:8]);
      recv(0, d); chk("R4 high byte second", d, VEC[v][7:0]);
      halt;
    end

    // R1: foreign address is refused and stores nothing
    go; send({7'h2B, 1'b0}, a); chk("R1 foreign address NACK", a, 0);
    send(8'h10, a); send(8'h99, a); chk("R1 foreign data NACK", a, 0); halt;
    go; send({OWN, 1'b0}, a); send(8'h10, a);
    go; send({OWN, 1'b1}, a); recv(0, d); chk("R1 register untouched", d, 8'hA5); halt;

    // R2/R5: lone command byte, then plain read
    go; send({OWN, 1'b0}, a); send(8'h00, a); chk("R2 lone command ACK", a, 1); halt;
    go; send({OWN, 1'b1}, a); recv(0, d); chk("R5 plain read uses command", d, 8'h12); halt;

    // R5/R8: byte-data write, later plain read, then clocks after NACK
    go; send({OWN, 1'b0}, a); send(8'h20, a); send(8'h77, a); halt;
    go; send({OWN, 1'b1}, a); recv(0, d); chk("R5 pointer kept across STOP", d, 8'h77);
    recv(0, d); chk("R8 released after host NACK", d, 8'hFF);
    chk("R8 line not driven", sda_oe, 0); halt;

    // R6/R7: short block, excess byte refused
    go; send({OWN, 1'b0}, a); send(8'hC0, a); send(8'h03, a); chk("R6 count ACK", a, 1);
    send(8'h11, a); chk("R6 data ACK", a, 1);
    send(8'h22, a); send(8'h33, a); chk("R6 last data ACK", a, 1);
    send(8'h44, a); chk("R6 byte past count NACK", a, 0); halt;
    go; send({OWN, 1'b0}, a); send(8'hC0, a);
    go; send({OWN, 1'b1}, a);
    recv(1, d); chk("R7 count first", d, 8'h03);
    recv(1, d); chk("R7 data 0", d, 8'h11);
    recv(1, d); chk("R7 data 1", d, 8'h22);
    recv(1, d); chk("R7 data 2", d, 8'h33);
    recv(0, d); chk("R6 refused byte not stored", d, 8'h00); halt;

    // R6: over-long count is capped at 32
    go; send({OWN, 1'b0}, a); send(8'hD0, a); send(8'd40, a);
    for (int i = 0; i < 33; i++) begin
      send(8'(i + 1), a);
      chk("R6 capped block ACK", a, (i < 32) ? 1 : 0);
    end
    halt;
    go; send({OWN, 1'b0}, a); send(8'hD0, a);
    go; send({OWN, 1'b1}, a); recv(0, d); chk("R6 stored count capped", d, 8'd32); halt;

    // R3/R4: process call
    go; send({OWN, 1'b0}, a); send(8'h30, a); send(8'hCD, a); send(8'hAB, a);
    go; send({OWN, 1'b1}, a);
    recv(1, d); chk("R4 process call low", d, 8'hCD);
    recv(0, d); chk("R4 process call high", d, 8'hAB); halt;

    chk("R9 drive began while SCL high", r9_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule